// File: doc/BRIEF.md
# Distributed Priority Bus Arbiter

This block settles ownership of one shared bus among up to sixteen requesters. Each requester sits behind its own local agent, and all agents share a small set of wired lines: a pending-request line, a hold line for long transfers, and a four-line priority bus. The priority bus is modelled as active-low, so a line that any agent pulls low reads as zero. A central controller opens a contest window of fixed length and then hands the bus over. It also watches how long the owner keeps the bus while others wait. No central encoder picks the winner. The agents compare their own fixed level with the shared priority bus one bit per window cycle, from the most significant bit down, and every agent that sees a better level drop out of the contest.

A device raises its request and keeps it up until its grant arrives. It then holds the grant for as long as it keeps the request up. The owner can raise its hold line to keep the bus through a long transfer. Without the hold line, an owner that ignores waiting requesters is pushed off the bus after a bounded time. A device that has just been served must wait for a cycle with no pending requests before it can compete again. Every waiter therefore gets its turn before any earlier owner comes back.

Top module: `prio_arb_top`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: Agent i has the fixed level i (4 bits). A contest is won by the agent with the numerically smallest level among the agents that were already waiting when the window opened. The comparison is exact for close levels such as 7 against 8.
- R3: The bus is idle and a request is first sampled at clock edge t. The grant then rises at edge t+1+ARB_CYC (default 4). A grant only ever rises on the edge right after a contest window cycle.
- R4: A request that is first sampled while a contest window is open does not take part in that contest. It takes part in the next one.
- R5: An owner keeps its grant while its request stays high. Its grant falls on the first edge that samples the request low. The next pending contest then grants on the edge ARB_CYC+2 edges after that fall.
- R6: An owner that does not hold the bus is forced off when another requester is waiting. The grant falls HOLD_TO+1 edges (default 17) after the edge that first samples the waiter's request.
- R7: While the owner holds the bus, it is never forced off and no contest window opens. The forcing count starts only when the hold ends, and the owner is forced off HOLD_TO+1 edges after the hold falls.
- R8: An agent that has been served does not compete again until it sees a cycle with no pending request. Under constant contention, every requester keeps being granted.
- R9: During and right after reset, no grant is high and no contest is open.
- R10: A hold request (`dev_burst_i`) from an agent that does not own the bus has no effect on the forcing time or on the grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | N_REQ | Per-device bus request, held until granted and kept for as long as the bus is wanted |
| dev_burst_i | input | N_REQ | Per-device hold request, used only while that device owns the bus |
| gnt_o | output | N_REQ | Per-device grant, high while the device owns the bus |

## Verification
Each result is tied to a cycle count from a stimulus. If the bus is idle, a request driven while the bench cycle counter reads n is granted when the counter reads n+ARB_CYC+2. A release driven at counter r leads to the next grant at r+ARB_CYC+3. A forced hand-over is due at n+HOLD_TO+ARB_CYC+4 from the waiter's request, and at m+HOLD_TO+ARB_CYC+3 from the fall of a hold at counter m. Each driver task pushes the expected winner together with the counter value at which it is due. The monitor samples on the falling clock edge and compares every rising grant against the head of that queue, so an early, late or unexpected grant is caught as well as a wrong winner.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_ARB   = 2'd1,
        CTL_GRANT = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        AG_IDLE = 2'd0,
        AG_WAIT = 2'd1,
        AG_OWN  = 2'd2,
        AG_COOL = 2'd3
    } ag_state_e;

    typedef struct packed {
        ag_state_e st;
        logic      alive;
    } ag_regs_t;

endpackage

// File: rtl/arb_lines.sv
module arb_lines #(
    parameter int N_REQ = 16,
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] prio_drv [N_REQ],
    input  logic [N_REQ-1:0] pend_drv,
    input  logic [N_REQ-1:0] hold_drv,
    input  logic [N_REQ-1:0] own_drv,
    output logic [LVL_W-1:0] prio_bus,
    output logic             pend_line,
    output logic             hold_line,
    output logic             owned_line
);

    // Active-low wired lines: any agent driving zero pulls the line low.
    always_comb begin
        prio_bus = '1;
        for (int i = 0; i < N_REQ; i++) begin
            prio_bus = prio_bus & prio_drv[i];
        end
    end

    assign pend_line  = |pend_drv;
    assign hold_line  = |hold_drv;
    assign owned_line = |own_drv;

endmodule

// File: rtl/arb_central.sv
module arb_central
    import arb_pkg::*;
#(
    parameter int ARB_CYC = 4,
    parameter int HOLD_TO = 16,
    localparam int CNT_W  = (ARB_CYC > 1) ? $clog2(ARB_CYC) : 1,
    localparam int TO_W   = $clog2(HOLD_TO + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_line,
    input  logic             hold_line,
    input  logic             owned_line,
    output logic             arb_phase,
    output logic [CNT_W-1:0] arb_cnt,
    output logic             force_off
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ARB_CYC - 1);
    localparam logic [TO_W-1:0]  TO_LIM   = TO_W'(HOLD_TO);

    typedef struct packed {
        ctl_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [TO_W-1:0]  to;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            CTL_IDLE: begin
                r_d.to  = '0;
                r_d.cnt = '0;
                if (pend_line && !hold_line) begin
                    r_d.st = CTL_ARB;
                end
            end
            CTL_ARB: begin
                if (r_q.cnt == LAST_CNT) begin
                    r_d.st  = CTL_GRANT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            CTL_GRANT: begin
                if (!owned_line) begin
                    r_d.st = CTL_IDLE;
                    r_d.to = '0;
                end else if (pend_line && !hold_line) begin
                    if (r_q.to != TO_LIM) begin
                        r_d.to = r_q.to + 1'b1;
                    end
                end else begin
                    r_d.to = '0;
                end
            end
            default: r_d.st = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: CTL_IDLE, cnt: '0, to: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign arb_phase = (r_q.st == CTL_ARB);
    assign arb_cnt   = r_q.cnt;
    assign force_off = (r_q.st == CTL_GRANT) && (r_q.to == TO_LIM);

endmodule

// File: rtl/arb_agent.sv
module arb_agent
    import arb_pkg::*;
#(
    parameter int LVL_W   = 4,
    parameter int ARB_CYC = 4,
    parameter logic [LVL_W-1:0] MY_LVL = '0,
    localparam int CNT_W  = (ARB_CYC > 1) ? $clog2(ARB_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_req,
    input  logic             dev_burst,
    input  logic             arb_phase,
    input  logic [CNT_W-1:0] arb_cnt,
    input  logic [LVL_W-1:0] prio_bus,
    input  logic             pend_line,
    input  logic             force_off,
    output logic [LVL_W-1:0] prio_drv,
    output logic             pend_drv,
    output logic             hold_drv,
    output logic             own_drv,
    output logic             gnt
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ARB_CYC - 1);

    ag_regs_t r_d, r_q;
    logic     drop_out;
    logic     wins;

    // One bit is resolved per window cycle, MSB first. Higher bits are
    // already settled, so only the current bit decides withdrawal.
    always_comb begin
        drop_out = 1'b0;
        for (int k = 0; k < LVL_W; k++) begin
            if (int'(arb_cnt) == (LVL_W - 1 - k)) begin
                drop_out = MY_LVL[k] && !prio_bus[k];
            end
        end
    end

    assign wins = arb_phase && (arb_cnt == LAST_CNT) && r_q.alive &&
                  !drop_out && (prio_bus == MY_LVL);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            AG_IDLE: begin
                r_d.alive = 1'b0;
                if (dev_req) begin
                    r_d.st = AG_WAIT;
                end
            end
            AG_WAIT: begin
                if (!arb_phase) begin
                    r_d.alive = 1'b1;
                end else if (wins) begin
                    r_d.st    = AG_OWN;
                    r_d.alive = 1'b0;
                end else begin
                    r_d.alive = r_q.alive && !drop_out;
                end
            end
            AG_OWN: begin
                if (!dev_req || force_off) begin
                    r_d.st = AG_COOL;
                end
            end
            AG_COOL: begin
                if (!pend_line) begin
                    r_d.st = AG_IDLE;
                end
            end
            default: r_d.st = AG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: AG_IDLE, alive: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign prio_drv = (r_q.st == AG_WAIT && arb_phase && r_q.alive) ? MY_LVL : '1;
    assign pend_drv = (r_q.st == AG_WAIT);
    assign own_drv  = (r_q.st == AG_OWN);
    assign hold_drv = (r_q.st == AG_OWN) && dev_burst;
    assign gnt      = (r_q.st == AG_OWN);

endmodule

// File: rtl/prio_arb_top.sv
module prio_arb_top #(
    parameter int N_REQ   = 16,
    parameter int LVL_W   = 4,
    parameter int ARB_CYC = 4,
    parameter int HOLD_TO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] dev_req_i,
    input  logic [N_REQ-1:0] dev_burst_i,
    output logic [N_REQ-1:0] gnt_o
);

    localparam int CNT_W = (ARB_CYC > 1) ? $clog2(ARB_CYC) : 1;

    logic [LVL_W-1:0] prio_drv [N_REQ];
    logic [N_REQ-1:0] pend_drv;
    logic [N_REQ-1:0] hold_drv;
    logic [N_REQ-1:0] own_drv;
    logic [LVL_W-1:0] prio_bus;
    logic             pend_line;
    logic             hold_line;
    logic             owned_line;
    logic             arb_phase;
    logic [CNT_W-1:0] arb_cnt;
    logic             force_off;

    arb_central #(
        .ARB_CYC (ARB_CYC),
        .HOLD_TO (HOLD_TO)
    ) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_line  (pend_line),
        .hold_line  (hold_line),
        .owned_line (owned_line),
        .arb_phase  (arb_phase),
        .arb_cnt    (arb_cnt),
        .force_off  (force_off)
    );

    arb_lines #(
        .N_REQ (N_REQ),
        .LVL_W (LVL_W)
    ) lines_i (
        .prio_drv   (prio_drv),
        .pend_drv   (pend_drv),
        .hold_drv   (hold_drv),
        .own_drv    (own_drv),
        .prio_bus   (prio_bus),
        .pend_line  (pend_line),
        .hold_line  (hold_line),
        .owned_line (owned_line)
    );

    for (genvar i = 0; i < N_REQ; i++) begin : g_agent
        localparam logic [LVL_W-1:0] AG_LVL = LVL_W'(i);
        arb_agent #(
            .LVL_W   (LVL_W),
            .ARB_CYC (ARB_CYC),
            .MY_LVL  (AG_LVL)
        ) agent_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .dev_req   (dev_req_i[i]),
            .dev_burst (dev_burst_i[i]),
            .arb_phase (arb_phase),
            .arb_cnt   (arb_cnt),
            .prio_bus  (prio_bus),
            .pend_line (pend_line),
            .force_off (force_off),
            .prio_drv  (prio_drv[i]),
            .pend_drv  (pend_drv[i]),
            .hold_drv  (hold_drv[i]),
            .own_drv   (own_drv[i]),
            .gnt       (gnt_o[i])
        );
    end

endmodule

// File: rtl/prio_arb_chk.sv
module prio_arb_chk #(
    parameter int N_REQ = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] dev_req_i,
    input logic [N_REQ-1:0] gnt_o,
    input logic             arb_phase,
    input logic             hold_line,
    input logic             force_off
);

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R3
    grant_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt_o) |-> $past(arb_phase));

    // R7
    no_window_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_line |-> !arb_phase);

    // R6
    forced_owner_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> ((gnt_o & $past(gnt_o)) == '0));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (gnt_o == '0) && !arb_phase);

    for (genvar i = 0; i < N_REQ; i++) begin : g_rel
        // R5
        release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[i] && !dev_req_i[i]) |=> !gnt_o[i]);
    end

endmodule

bind prio_arb_top prio_arb_chk #(.N_REQ(N_REQ)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req_i (dev_req_i),
    .gnt_o     (gnt_o),
    .arb_phase (arb_phase),
    .hold_line (hold_line),
    .force_off (force_off)
);

// File: tb/prio_arb_tb.sv
module prio_arb_top_tb_top;

    localparam int N       = 16;
    localparam int ARB_CYC = 4;
    localparam int HOLD_TO = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_burst = '0;
    logic [N-1:0] gnt;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit sb_on = 1'b1;
    bit done = 1'b0;
    logic [N-1:0] prev_gnt = '0;

    int exp_id [$];
    int exp_cyc [$];

    prio_arb_top #(
        .N_REQ   (N),
        .LVL_W   (4),
        .ARB_CYC (ARB_CYC),
        .HOLD_TO (HOLD_TO)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_req_i   (dev_req),
        .dev_burst_i (dev_burst),
        .gnt_o       (gnt)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int id, input int due);
        exp_id.push_back(id);
        exp_cyc.push_back(due);
    endtask

    // Monitor: scoreboard of grant rises, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N-1:0] rise;
            int who;
            check($countones(gnt) <= 1, "R1 grants at once", $countones(gnt), 1);
            rise = gnt & ~prev_gnt;
            if (rise != '0 && sb_on) begin
                who = -1;
                for (int i = 0; i < N; i++) if (rise[i]) who = i;
                if (exp_id.size() == 0) begin
                    check(1'b0, "R2 unexpected grant", who, -1);
                end else begin
                    int eid;
                    int ec;
                    eid = exp_id.pop_front();
                    ec  = exp_cyc.pop_front();
                    check(who == eid, "R2 winner", who, eid);
                    if (ec >= 0) check(cyc == ec, "R3/R5/R6/R7 grant cycle", cyc, ec);
                end
            end
            prev_gnt = gnt;
        end
    end

    task automatic wait_gnt(input int id);
        while (!gnt[id]) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drop the owner's request; push the next winner due after the fall.
    task automatic release_to(input int id, input int next_id);
        dev_req[id] = 1'b0;
        if (next_id >= 0) push(next_id, cyc + ARB_CYC + 3);
        @(negedge clk);
        check(!gnt[id], "R5 grant falls after release", gnt[id], 0);
    endtask

    task automatic contest3(input int a, input int b, input int c);
        dev_req[a] = 1'b1;
        dev_req[b] = 1'b1;
        dev_req[c] = 1'b1;
        push(a, cyc + ARB_CYC + 2);
        wait_gnt(a);
        idle(3);
        check(gnt[a], "R5 owner keeps grant", gnt[a], 1);
        release_to(a, b);
        wait_gnt(b);
        idle(2);
        release_to(b, c);
        wait_gnt(c);
        idle(2);
        release_to(c, -1);
        idle(12);
    endtask

    initial begin
        int n;
        int fair_cnt [N];
        int hold_cnt [N];
        idle(3);
        check(gnt == '0, "R9 no grant in reset", int'(gnt), 0);
        rst_n = 1'b1;
        idle(3);
        check(gnt == '0, "R9 no grant after reset", int'(gnt), 0);

        // R2 three-way contest
        @(negedge clk);
        contest3(5, 9, 12);
        // R2 close levels 7 against 8
        @(negedge clk);
        dev_req[8] = 1'b1;
        dev_req[7] = 1'b1;
        push(7, cyc + ARB_CYC + 2);
        wait_gnt(7);
        idle(2);
        release_to(7, 8);
        wait_gnt(8);
        release_to(8, -1);
        idle(12);
        // R2 extremes
        contest3(0, 6, 15);

        // R4 late arrival is kept out of the open window
        dev_req[10] = 1'b1;
        push(10, cyc + ARB_CYC + 2);
        idle(2);
        dev_req[3] = 1'b1;
        wait_gnt(10);
        idle(2);
        check(gnt[10] && !gnt[3], "R4 late request excluded", int'(gnt[3]), 0);
        release_to(10, 3);
        wait_gnt(3);
        release_to(3, -1);
        idle(12);

        // R6 forced release, with R10 hold from a non-owner
        dev_req[2] = 1'b1;
        push(2, cyc + ARB_CYC + 2);
        wait_gnt(2);
        idle(2);
        dev_req[1] = 1'b1;
        dev_burst[1] = 1'b1;
        push(1, cyc + HOLD_TO + ARB_CYC + 4);
        n = cyc;
        wait_gnt(1);
        dev_req[2] = 1'b0;
        check(cyc == n + HOLD_TO + ARB_CYC + 4, "R10 non-owner hold ignored",
              cyc - n, HOLD_TO + ARB_CYC + 4);
        check(!gnt[2], "R6 forced owner off", gnt[2], 0);
        dev_burst[1] = 1'b0;
        idle(2);
        release_to(1, -1);
        idle(12);

        // R7 hold keeps the bus past the timeout
        dev_burst[4] = 1'b1;
        dev_req[4] = 1'b1;
        push(4, cyc + ARB_CYC + 2);
        wait_gnt(4);
        dev_req[6] = 1'b1;
        idle(HOLD_TO + 24);
        check(gnt[4] && !gnt[6], "R7 owner kept during hold", int'(gnt[4]), 1);
        dev_burst[4] = 1'b0;
        push(6, cyc + HOLD_TO + ARB_CYC + 3);
        wait_gnt(6);
        dev_req[4] = 1'b0;
        idle(2);
        release_to(6, -1);
        idle(12);
        check(exp_id.size() == 0, "R2 all expected grants seen", exp_id.size(), 0);

        // R8 sustained contention: no starvation
        sb_on = 1'b0;
        for (int i = 0; i < N; i++) begin
            fair_cnt[i] = 0;
            hold_cnt[i] = 0;
        end
        for (int t = 0; t < 700; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (i == 0 || i == 8 || i == 15) begin
                    if (gnt[i]) begin
                        if (hold_cnt[i] == 0) fair_cnt[i]++;
                        hold_cnt[i]++;
                    end else begin
                        hold_cnt[i] = 0;
                    end
                    dev_req[i] = !(gnt[i] && hold_cnt[i] >= 6);
                end
            end
        end
        dev_req = '0;
        idle(30);
        check(fair_cnt[0] >= 5, "R8 agent 0 served", fair_cnt[0], 5);
        check(fair_cnt[8] >= 5, "R8 agent 8 served", fair_cnt[8], 5);
        check(fair_cnt[15] >= 5, "R8 agent 15 served", fair_cnt[15], 5);
        check(gnt == '0, "R8 bus idle after traffic", int'(gnt), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule